// File: doc/BRIEF.md
# Resolution-Programmable Tracking Angle Counter

This block keeps the digital shaft angle of a tracking converter as a 16-bit natural-binary word. The top bit is worth 180 degrees, and each lower bit is worth half of the bit above it. A tracking loop sends it single-cycle step requests, each with a direction. Each accepted request moves the angle by one least-significant step of the active resolution, wraps modulo a full turn, and raises a busy pulse that lasts a fixed number of clock cycles.

A 2-bit resolution code selects 10, 12, 14 or 16 significant bits. The code is taken in only at the trailing edge of a busy pulse, so the step weight never changes in the middle of a count. When a coarser setting takes effect, the low bits of the angle are cleared. A request that arrives during a pulse waits in a single pending slot and is launched once the pulse is over. A preset input loads the angle directly. It is used when the word is supplied from outside, as when the converter acts as a control transformer.

Top module: `trk_angle_counter`

## Requirements
- R1: After synchronous reset, `angle` is 0, `busy` is 0 and `res_active` is 2'b11 (16-bit).
- R2: Resolution code `{B,A}` = 2'b00, 2'b01, 2'b10, 2'b11 selects 10, 12, 14, 16 bits. One step in code c moves the word by 2^(6-2c), so codes 00, 01, 10 and 11 give steps of 64, 16, 4 and 1.
- R3: An accepted step with `step_up`=1 adds one step to the angle, and with `step_up`=0 subtracts it, wrapping modulo 2^16 in both directions.
- R4: Every accepted step raises `busy` on the same clock edge that changes the angle. `busy` stays high for exactly BUSY_CYCLES cycles.
- R5: The angle changes only on a busy rising edge, on a preset, or on the busy falling edge (truncation).
- R6: `res_sel` is sampled only on the clock edge where `busy` falls. Changes at any other time have no effect on `res_active` or the angle.
- R7: Angle bits below the active resolution always read 0. When a coarser resolution takes effect, those bits of the current angle are cleared.
- R8: A request that arrives while `busy` is high is held in one pending slot. It is launched on the first edge after `busy` falls, which leaves `busy` low for exactly one cycle between the two pulses.
- R9: A request that arrives while the pending slot is full is discarded.
- R10: `preset_en` loads `preset_val` masked to the active resolution on the next edge, without raising `busy`. A step requested in the same cycle is deferred to the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_req | input | 1 | Single-cycle step request from the tracking loop |
| step_up | input | 1 | Step direction, 1 = increase angle |
| res_sel | input | 2 | Requested resolution code {B,A} |
| preset_en | input | 1 | Load `preset_val` into the angle |
| preset_val | input | 16 | Angle value to load |
| angle | output | 16 | Angle word, bit 15 = 180 degrees |
| busy | output | 1 | Busy pulse, one per accepted step |
| res_active | output | 2 | Resolution code currently in force |

## Verification
If the held resolution code is wrong, the step size is wrong from the very next busy rising edge. Low bits also stay non-zero after a busy falling edge that should have cleared them. Both show on `angle` within one cycle of the edge concerned. A faulty busy counter or pending slot shows as a pulse of the wrong length, a missing low cycle between back-to-back pulses, or a final angle off by one step once the queued requests have drained.

// File: rtl/trk_pkg.sv
package trk_pkg;

    localparam int ANGLE_BITS    = 16;
    localparam int RES_CODE_BITS = 2;
    localparam int RES_STEP_BITS = 2;
    localparam int NUM_RES       = 1 << RES_CODE_BITS;

    typedef logic [ANGLE_BITS-1:0] angle_t;

    typedef enum logic [RES_CODE_BITS-1:0] {
        RES_10 = 2'b00,
        RES_12 = 2'b01,
        RES_14 = 2'b10,
        RES_16 = 2'b11
    } res_e;

    typedef struct packed {
        logic valid;
        logic up;
    } step_t;

    // number of angle bits below the active resolution
    function automatic int unsigned res_shift(res_e r);
        return (NUM_RES - 1 - int'(r)) * RES_STEP_BITS;
    endfunction

    function automatic angle_t res_mask(res_e r);
        angle_t ones;
        ones = '1;
        return ones << res_shift(r);
    endfunction

    function automatic angle_t step_delta(res_e r);
        angle_t one;
        one = angle_t'(1);
        return one << res_shift(r);
    endfunction

endpackage

// File: rtl/trk_busy_timer.sv
module trk_busy_timer #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic busy_end
);
    localparam int CW = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign busy_end = busy_q && (cnt_q == CW'(BUSY_CYCLES - 1));
    assign busy     = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (busy_end) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/trk_step_slot.sv
module trk_step_slot (
    input  logic clk,
    input  logic rst,
    input  logic step_req,
    input  logic step_up,
    input  logic busy,
    input  logic hold,
    output logic launch,
    output logic launch_up
);
    import trk_pkg::*;

    step_t pend_q;
    step_t pend_d;
    logic  can_go;

    assign can_go = !busy && !hold;

    always_comb begin
        pend_d    = pend_q;
        launch    = 1'b0;
        launch_up = 1'b0;
        if (pend_q.valid) begin
            launch    = can_go;
            launch_up = pend_q.up;
            if (can_go) begin
                pend_d.valid = step_req;
                pend_d.up    = step_up;
            end
        end else begin
            launch    = can_go && step_req;
            launch_up = step_up;
            if (step_req && !can_go) begin
                pend_d.valid = 1'b1;
                pend_d.up    = step_up;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end
endmodule

// File: rtl/trk_angle_reg.sv
module trk_angle_reg (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    launch,
    input  logic                    launch_up,
    input  logic                    busy_end,
    input  logic [1:0]              res_sel,
    input  logic                    preset_en,
    input  trk_pkg::angle_t         preset_val,
    output trk_pkg::angle_t         angle,
    output trk_pkg::res_e           res_active
);
    import trk_pkg::*;

    angle_t angle_q;
    res_e   res_q;
    res_e   res_next;
    res_e   res_in;

    assign res_in   = res_e'(res_sel);
    assign res_next = busy_end ? res_in : res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            angle_q <= '0;
            res_q   <= RES_16;
        end else begin
            res_q <= res_next;
            if (preset_en)
                angle_q <= preset_val & res_mask(res_next);
            else if (launch)
                angle_q <= launch_up ? angle_q + step_delta(res_q)
                                     : angle_q - step_delta(res_q);
            else if (busy_end)
                angle_q <= angle_q & res_mask(res_in);
        end
    end

    assign angle      = angle_q;
    assign res_active = res_q;
endmodule

// File: rtl/trk_angle_counter.sv
module trk_angle_counter #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step_req,
    input  logic        step_up,
    input  logic [1:0]  res_sel,
    input  logic        preset_en,
    input  logic [15:0] preset_val,
    output logic [15:0] angle,
    output logic        busy,
    output logic [1:0]  res_active
);
    import trk_pkg::*;

    logic   launch;
    logic   launch_up;
    logic   busy_end;
    angle_t angle_w;
    res_e   res_w;

    trk_step_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .step_req  (step_req),
        .step_up   (step_up),
        .busy      (busy),
        .hold      (preset_en),
        .launch    (launch),
        .launch_up (launch_up)
    );

    trk_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (launch),
        .busy     (busy),
        .busy_end (busy_end)
    );

    trk_angle_reg u_angle (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_up  (launch_up),
        .busy_end   (busy_end),
        .res_sel    (res_sel),
        .preset_en  (preset_en),
        .preset_val (preset_val),
        .angle      (angle_w),
        .res_active (res_w)
    );

    assign angle      = angle_w;
    assign res_active = res_w;
endmodule

// File: rtl/trk_angle_counter_chk.sv
module trk_angle_counter_chk #(
    parameter int BUSY_CYCLES = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        preset_en,
    input logic [15:0] angle,
    input logic [1:0]  res_active
);
    import trk_pkg::*;

    localparam int RW = $clog2(BUSY_CYCLES + 2);

    logic          armed_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            run_q   <= '0;
        end else begin
            armed_q <= 1'b1;
            run_q   <= busy ? run_q + RW'(1) : '0;
        end
    end

    AST_STEP_ONE_LSB: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $rose(busy)) |->
            ((angle == $past(angle) + step_delta(res_e'(res_active))) ||
             (angle == $past(angle) - step_delta(res_e'(res_active))))); // R3

    AST_BUSY_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $fell(busy)) |-> (run_q == RW'(BUSY_CYCLES))); // R4

    AST_BUSY_MAX: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < RW'(BUSY_CYCLES))); // R4

    AST_ANGLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (armed_q && (angle != $past(angle))) |->
            ($rose(busy) || $fell(busy) || $past(preset_en))); // R5

    AST_RES_AT_TRAIL: assert property (@(posedge clk) disable iff (rst)
        (armed_q && (res_active != $past(res_active))) |-> $fell(busy)); // R6

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> ((angle & ~res_mask(res_e'(res_active))) == '0)); // R7

endmodule

bind trk_angle_counter trk_angle_counter_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .preset_en  (preset_en),
    .angle      (angle),
    .res_active (res_active)
);

// File: tb/tb_trk_angle_counter.sv
module tb_trk_angle_counter;

    localparam int BUSY_CYCLES = 4;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [1:0]  sel;
        logic        up;
        logic [15:0] at_launch;
        logic [15:0] at_end;
        logic [1:0]  res_end;
    } vec_t;

    // walked from reset: angle 0, 16-bit resolution
    localparam vec_t VEC [NVEC] = '{
        '{2'b11, 1'b1, 16'h0001, 16'h0001, 2'b11},
        '{2'b11, 1'b0, 16'h0000, 16'h0000, 2'b11},
        '{2'b11, 1'b0, 16'hFFFF, 16'hFFFF, 2'b11},
        '{2'b10, 1'b1, 16'h0000, 16'h0000, 2'b10},
        '{2'b10, 1'b0, 16'hFFFC, 16'hFFFC, 2'b10},
        '{2'b00, 1'b1, 16'h0000, 16'h0000, 2'b00},
        '{2'b00, 1'b0, 16'hFFC0, 16'hFFC0, 2'b00},
        '{2'b01, 1'b0, 16'hFF80, 16'hFF80, 2'b01},
        '{2'b01, 1'b1, 16'hFF90, 16'hFF90, 2'b01},
        '{2'b00, 1'b1, 16'hFFA0, 16'hFF80, 2'b00},
        '{2'b11, 1'b1, 16'hFFC0, 16'hFFC0, 2'b11},
        '{2'b11, 1'b1, 16'hFFC1, 16'hFFC1, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        step_req;
    logic        step_up;
    logic [1:0]  res_sel;
    logic        preset_en;
    logic [15:0] preset_val;
    logic [15:0] angle;
    logic        busy;
    logic [1:0]  res_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trk_angle_counter #(.BUSY_CYCLES(BUSY_CYCLES)) dut (
        .clk        (clk),
        .rst        (rst),
        .step_req   (step_req),
        .step_up    (step_up),
        .res_sel    (res_sel),
        .preset_en  (preset_en),
        .preset_val (preset_val),
        .angle      (angle),
        .busy       (busy),
        .res_active (res_active)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic preset(logic [15:0] v);
        preset_en  = 1'b1;
        preset_val = v;
        tick();
        preset_en  = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 40 && busy; k++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; step_req = 1'b0; step_up = 1'b0; res_sel = 2'b11;
        preset_en = 1'b0; preset_val = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 angle", 32'(angle), 32'h0);
        check("R1 busy", 32'(busy), 32'h0);
        check("R1 res", 32'(res_active), 32'h3);

        // R2 R3 R4 R6 R7 table walk
        for (int i = 0; i < NVEC; i++) begin
            res_sel  = VEC[i].sel;
            step_up  = VEC[i].up;
            step_req = 1'b1;
            tick();
            step_req = 1'b0;
            check("R3 launch angle", 32'(angle), 32'(VEC[i].at_launch));
            check("R4 busy high", 32'(busy), 32'h1);
            repeat (BUSY_CYCLES) tick();
            check("R4 busy low", 32'(busy), 32'h0);
            check("R7 end angle", 32'(angle), 32'(VEC[i].at_end));
            check("R6 res after trail", 32'(res_active), 32'(VEC[i].res_end));
        end

        // R6 res_sel change while idle is ignored
        res_sel = 2'b00;
        repeat (3) tick();
        check("R6 idle res", 32'(res_active), 32'h3);
        check("R6 idle angle", 32'(angle), 32'hFFC1);
        res_sel = 2'b11;

        // R8 pending request launches after one low cycle
        preset(16'h0100);
        step_up = 1'b1; step_req = 1'b1;
        tick();
        tick();
        step_req = 1'b0;
        repeat (3) tick();
        check("R8 gap busy", 32'(busy), 32'h0);
        check("R8 gap angle", 32'(angle), 32'h0101);
        tick();
        check("R8 second busy", 32'(busy), 32'h1);
        check("R8 second angle", 32'(angle), 32'h0102);
        wait_idle();

        // R9 request while slot full is dropped
        preset(16'h0200);
        step_up = 1'b1; step_req = 1'b1;
        tick();
        tick();
        step_up = 1'b0;
        tick();
        step_req = 1'b0;
        repeat (14) tick();
        check("R9 final angle", 32'(angle), 32'h0202);
        check("R9 idle", 32'(busy), 32'h0);

        // R10 preset without busy
        preset(16'h1234);
        check("R10 preset angle", 32'(angle), 32'h1234);
        check("R10 preset no busy", 32'(busy), 32'h0);

        // R10 preset and step in the same cycle
        preset_en = 1'b1; preset_val = 16'h0040;
        step_up = 1'b1; step_req = 1'b1;
        tick();
        preset_en = 1'b0; step_req = 1'b0;
        check("R10 preset wins", 32'(angle), 32'h0040);
        check("R10 deferred idle", 32'(busy), 32'h0);
        tick();
        check("R10 deferred step", 32'(angle), 32'h0041);
        wait_idle();

        // R7 truncation on switch to coarser, then masked preset
        res_sel = 2'b00; step_up = 1'b1; step_req = 1'b1;
        tick();
        step_req = 1'b0;
        wait_idle();
        check("R7 truncated", 32'(angle), 32'h0040);
        check("R2 res 10", 32'(res_active), 32'h0);
        preset(16'h1234);
        check("R7 masked preset", 32'(angle), 32'h1200);

        // R2 R3 down step of 64 at 10-bit, R4 pulse length
        step_up = 1'b0; step_req = 1'b1;
        tick();
        step_req = 1'b0;
        begin
            int n;
            n = 0;
            for (int k = 0; k < 20; k++) begin
                if (busy) n++;
                tick();
            end
            check("R4 width", 32'(n), 32'(BUSY_CYCLES));
        end
        check("R3 down 10-bit", 32'(angle), 32'h11C0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule